// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line) that exposes a small bank of byte-wide configuration registers. Typical contents are per-output enable bits. Every register drives a parallel output continuously. Every register also takes a fixed default value at reset, so a system that never touches the bus still gets a working configuration.

A master writes the slave address with the direction bit clear and then sends a command byte. Bit 7 of the command selects the access type. When it is set, the access is a single indexed byte, and bits 6:0 give the offset. When it is clear, the access is a sequential block that always starts at offset 0. A block write sends a byte count and then data. A block read is started with a repeated START and the read address. It returns the register count first and then the registers from offset 0 upward. The master may end any block after a whole byte.

Both lines are oversampled with the system clock. START and STOP are recognised from the data line moving while the clock line is high. The slave drives the data line only by pulling it low, and only changes that drive while the clock line is low.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset, byte i of `cfg_o` (bits 8i+7:8i) equals 0x80 + 0x11·i for i = 0..7, and `sda_oe` is low.
- R2: An address byte whose upper seven bits are 0x69 is acknowledged. A write uses 0xD2 and a read uses 0xD3. Any other address is not acknowledged, and the slave ignores the bus until the next START.
- R3: A START (data falling while clock high) always restarts the address phase and releases the data line, including a repeated START in the middle of a transfer. A STOP (data rising while clock high) returns the slave to idle with the data line released.
- R4: Bytes are shifted most significant bit first in both directions. The slave's data drive changes only while the clock line is low.
- R5: For a byte write, the command is 0x80 | offset, and the next data byte is written to that offset. Any further data byte in the same transfer is not acknowledged and is not written.
- R6: For a block write, the command is 0x00 and is followed by a count byte. The data bytes then go to offsets 0, 1, 2, … A data byte beyond the count is not acknowledged and is not written. Ending early leaves the higher offsets unchanged.
- R7: For a byte read, the master writes the command 0x80 | offset, sends a repeated START and then 0xD3. The first byte returned is the register at that offset. Each byte the master acknowledges is followed by the next offset.
- R8: For a block read, the command is 0x00. The first byte returned is the register count (8), followed by offsets 0, 1, … in order. A master NACK ends the read, and the slave releases the data line.
- R9: A write to an offset of 8 or more is acknowledged but changes no register. A read from such an offset returns 0x00.
- R10: After each byte it accepts, the slave pulls the data line low for the whole of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| cfg_o | output | NUM_REGS*8 | Register contents, byte i at bits 8i+7:8i |

## Verification
The address handling is tried with all 128 seven-bit addresses, which separates the single matching value from every near miss. Byte writes and byte reads are swept over offsets 0 to 9 with distinct data at each offset. This exposes wrong indexing, a wrong shift order, and any leak past the end of the bank. Block writes are run with counts 1 to 8, one byte past the count and an early STOP, which tells apart correct count limiting from simple offset wrapping. Block reads are run up to and past the end of the bank, which checks the count byte, the order of the data and the zero fill.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twr_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_COUNT,
    K_DATA
  } twr_kind_e;

  // next byte pointer, holds at the top of the 7-bit offset space
  function automatic logic [6:0] ptr_step(input logic [6:0] p);
    return (p == 7'h7F) ? p : p + 7'd1;
  endfunction

  // address byte carries the 7-bit device address above the direction bit
  function automatic logic addr_is(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // command bit 7 set means single indexed byte access
  function automatic logic cmd_is_single(input logic [7:0] c);
    return c[7];
  endfunction

  function automatic logic [6:0] cmd_start_ptr(input logic [7:0] c);
    return c[7] ? c[6:0] : 7'd0;
  endfunction

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
  parameter int N    = 8,
  parameter int W    = 8,
  parameter int IDXW = 7,
  parameter logic [N*W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [W-1:0]    wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [W-1:0]    rd_data,
  output logic [N*W-1:0]  regs_o
);

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RST_VAL[g*W +: W];
      else if (wr_en && (wr_idx == IDXW'(g)))
        regs[g] <= wr_data;
    end
    assign regs_o[g*W +: W] = regs[g];
  end

  // offsets past the bank read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == IDXW'(i)) rd_data = regs[i];
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDXW'(N))) |=> $stable(regs_o)); // R9

endmodule

// File: rtl/twr_proto_fsm.sv
module twr_proto_fsm
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int N    = 8,
  parameter int IDXW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic [IDXW-1:0] rd_idx,
  input  logic [7:0]      rd_data
);

  twr_state_e      state;
  twr_kind_e       kind;
  logic [3:0]      bitcnt;
  logic [7:0]      rx_sh, tx_sh, left;
  logic [IDXW-1:0] ptr;
  logic            single, cnt_pend, wr_done, mack;

  // named events
  logic       rx_byte_done, addr_hit, addr_miss, accept;
  logic [7:0] tx_next;

  assign rx_byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit     = addr_is(rx_sh, DEV_ADDR);
  assign addr_miss    = rx_byte_done && (kind == K_ADDR) && !addr_hit;
  assign tx_next      = cnt_pend ? 8'(N) : rd_data;

  always_comb begin
    unique case (kind)
      K_ADDR:  accept = addr_hit;
      K_CMD:   accept = 1'b1;
      K_COUNT: accept = 1'b1;
      default: accept = single ? !wr_done : (left != 8'd0);
    endcase
  end

  assign wr_en   = rx_byte_done && (kind == K_DATA) && accept;
  assign wr_idx  = ptr;
  assign wr_data = rx_sh;
  assign rd_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      left     <= '0;
      ptr      <= '0;
      single   <= 1'b0;
      cnt_pend <= 1'b0;
      wr_done  <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && (bitcnt < 4'd8)) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (rx_byte_done) begin
            if (accept) begin
              sda_oe <= 1'b1;
              state  <= ST_RX_ACK;
              unique case (kind)
                K_ADDR: if (!rx_sh[0]) kind <= K_CMD;
                K_CMD: begin
                  single   <= cmd_is_single(rx_sh);
                  ptr      <= cmd_start_ptr(rx_sh);
                  cnt_pend <= !cmd_is_single(rx_sh);
                  wr_done  <= 1'b0;
                  kind     <= cmd_is_single(rx_sh) ? K_DATA : K_COUNT;
                end
                K_COUNT: begin
                  left <= rx_sh;
                  kind <= K_DATA;
                end
                default: begin
                  if (single) wr_done <= 1'b1;
                  else begin
                    ptr  <= ptr_step(ptr);
                    left <= left - 8'd1;
                  end
                end
              endcase
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_ADDR) begin
              // acknowledged read address: first byte goes out now
              tx_sh  <= tx_next;
              sda_oe <= ~tx_next[7];
              state  <= ST_TX;
              if (cnt_pend) cnt_pend <= 1'b0;
              else          ptr      <= ptr_step(ptr);
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              tx_sh  <= tx_next;
              sda_oe <= ~tx_next[7];
              bitcnt <= '0;
              state  <= ST_TX;
              if (cnt_pend) cnt_pend <= 1'b0;
              else          ptr      <= ptr_step(ptr);
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX) && !sda_oe); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_oe); // R3
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R4
  AST_ADDR_MISS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> (state == ST_IDLE) && !sda_oe); // R2
  AST_MNACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX_ACK && scl_fall && !mack && !start_det && !stop_det)
      |=> (state == ST_IDLE) && !sda_oe); // R8

endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = 64'hF7E6D5C4B3A29180
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int BYTE_W = 8;
  localparam int IDXW   = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDXW-1:0]   wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twr_proto_fsm #(.DEV_ADDR(DEV_ADDR), .N(NUM_REGS), .IDXW(IDXW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );

  twr_regbank #(.N(NUM_REGS), .W(BYTE_W), .IDXW(IDXW), .RST_VAL(RST_VAL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (cfg_o)
  );

endmodule

// File: tb/tb_cfg_twowire_slave.sv
module tb_cfg_twowire_slave;

  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [63:0] cfg_o;
  logic sda_line;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cfg_twowire_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    return 8'h80 + 8'(8'h11 * i);
  endfunction

  function automatic logic [63:0] model_flat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic bus_start();
    tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    end
    tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); m_sda = give_ack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] rb;
    for (int i = 0; i < 8; i++) model[i] = dflt(i);
    tick(4); rst_n = 1'b1; tick(4);

    // R1 reset state
    chk(cfg_o == model_flat(), "R1 reset cfg", cfg_o, model_flat());
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);

    // R2 full address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start(); wr_byte({7'(a), 1'b0}, a0); bus_stop();
      chk(a0 == (a == 7'h69), "R2 address ack", a0, a == 7'h69);
    end
    // R2 after a miss, later bytes are ignored
    bus_start(); wr_byte(8'hA4, a0); wr_byte(8'h81, a1); wr_byte(8'h00, a2); bus_stop();
    chk(!a1 && !a2, "R2 ignored after miss", {a1, a2}, 0);
    chk(cfg_o == model_flat(), "R2 no write after miss", cfg_o, model_flat());

    // R5 R9 R10 byte write sweep over offsets 0..9
    for (int off = 0; off < 10; off++) begin
      logic [7:0] d;
      d = 8'h3C ^ 8'(off * 8'h1D);
      bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h80 | 8'(off), a1); wr_byte(d, a2);
      wr_byte(~d, a3); bus_stop();
      if (off < 8) model[off] = d;
      chk(a0 && a1 && a2, "R10 ack addr/cmd/data", {a0, a1, a2}, 3'b111);
      chk(!a3, "R5 second byte nack", a3, 0);
      chk(cfg_o == model_flat(), off < 8 ? "R5 byte write" : "R9 out of range write", cfg_o, model_flat());
    end

    // R4 MSB first: 0x01 must land as 0x01
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h82, a1); wr_byte(8'h01, a2); bus_stop();
    model[2] = 8'h01;
    chk(cfg_o[23:16] == 8'h01, "R4 bit order", cfg_o[23:16], 8'h01);

    // R7 R9 byte read sweep
    for (int off = 0; off < 10; off++) begin
      logic [7:0] e;
      e = (off < 8) ? model[off] : 8'h00;
      bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h80 | 8'(off), a1);
      bus_start(); wr_byte(8'hD3, a2); rd_byte(1'b0, rb); tick(2);
      chk(a2, "R2 read address ack", a2, 1);
      chk(rb == e, off < 8 ? "R7 byte read" : "R9 out of range read", rb, e);
      chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
      bus_stop();
    end
    // R7 continuation from offset 6
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h86, a1);
    bus_start(); wr_byte(8'hD3, a2);
    rd_byte(1'b1, rb); chk(rb == model[6], "R7 cont 6", rb, model[6]);
    rd_byte(1'b1, rb); chk(rb == model[7], "R7 cont 7", rb, model[7]);
    rd_byte(1'b0, rb); chk(rb == 8'h00, "R9 cont past end", rb, 0);
    bus_stop();

    // R6 block write counts 1..8, one byte past the count
    for (int n = 1; n <= 8; n++) begin
      bit okall;
      okall = 1'b1;
      bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); wr_byte(8'(n), a2);
      okall = a0 & a1 & a2;
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'(n * 16 + k);
        wr_byte(d, a3);
        okall &= a3;
        model[k] = d;
      end
      wr_byte(8'hEE, a3); bus_stop();
      chk(okall, "R6 block acks", okall, 1);
      chk(!a3, "R6 past count nack", a3, 0);
      chk(cfg_o == model_flat(), "R6 block write", cfg_o, model_flat());
    end
    // R6 early stop
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); wr_byte(8'd5, a2);
    wr_byte(8'h5A, a3); model[0] = 8'h5A; wr_byte(8'hA5, a3); model[1] = 8'hA5; bus_stop();
    chk(cfg_o == model_flat(), "R6 early stop", cfg_o, model_flat());

    // R3 repeated START aborts a write in progress
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h83, a1);
    bus_start(); wr_byte(8'hD2, a2); wr_byte(8'h84, a3); wr_byte(8'h77, a0); bus_stop();
    model[4] = 8'h77;
    chk(a2 && cfg_o == model_flat(), "R3 repeated start", cfg_o, model_flat());

    // R8 R9 block read past the end
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1);
    bus_start(); wr_byte(8'hD3, a2);
    rd_byte(1'b1, rb); chk(rb == 8'd8, "R8 count byte", rb, 8);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] e;
      e = (k < 8) ? model[k] : 8'h00;
      rd_byte(k != 8, rb);
      chk(rb == e, k < 8 ? "R8 block read" : "R9 block read past end", rb, e);
    end
    tick(2);
    chk(sda_oe == 1'b0, "R8 release", sda_oe, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R3 idle after stop", sda_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule